// File: doc/BRIEF.md
# Interrupt Flag and Gating Unit

This block collects the interrupt sources of a small 8-bit microcontroller and turns them into two plain control outputs: a request to the CPU and a wake-up line for a sleeping core. It has three core sources. The first is an external pin whose active edge is programmable. The second is a one-cycle overflow pulse from an 8-bit timer. The third is any change on a 4-bit slice of an input port. It also takes a group of peripheral flag/enable pairs whose flags and enables live elsewhere.

The core sources latch into sticky flags inside one 8-bit control register. Software reads and writes that register over a simple single-cycle register bus. The two outputs are control pins with no handshake.

The wake-up line depends only on each source's own enable. The peripheral group is additionally gated by its group enable. The CPU request is the wake-up condition further qualified by the global enable. This lets a core wake from sleep and either vector or simply resume.

Top module: `intc_gate`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, the control register reads 0x00 and both `cpu_irq` and `wake` are low.
- R2: Control register layout: bit 7 global enable, bit 6 peripheral-group enable, bit 5 timer enable, bit 4 external enable, bit 3 port-change enable, bit 2 timer flag, bit 1 external flag, bit 0 port-change flag. A write with `reg_wr` high loads all eight bits. The value is visible on `reg_rdata` from the next cycle.
- R3: The external pin passes through a two-stage synchronizer. An active edge sets bit 1, and the bit reads 1 three rising clock edges after the pin changes. The active edge is rising when `edge_rise` is 1 and falling when it is 0. The inactive edge leaves bit 1 unchanged.
- R4: A high `tmr_ovf` in one cycle sets bit 2 at the next clock edge.
- R5: Any change in the value of `port_hi` sets bit 0, after the same two-stage synchronization and three-edge latency as R3.
- R6: Flags are sticky. A flag falls only through a software write of 0.
- R7: If hardware sets a flag in the same cycle that software writes it, the flag reads 1 afterwards.
- R8: `wake` is high exactly when one of these holds: (bit0 AND bit3), (bit1 AND bit4), (bit2 AND bit5), or (bit6 AND any `per_flag[i]` AND `per_en[i]`). The global enable has no effect on it.
- R9: `cpu_irq` equals `wake` AND bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| edge_rise | input | 1 | 1 selects the rising edge, 0 the falling edge |
| port_hi | input | 4 | Asynchronous watched port bits |
| tmr_ovf | input | 1 | Timer rollover pulse, one cycle |
| per_flag | input | NPER | Peripheral interrupt flags |
| per_en | input | NPER | Peripheral interrupt enables |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register contents |
| cpu_irq | output | 1 | Interrupt request to the CPU |
| wake | output | 1 | Wake-up request to the sleep controller |

## Verification
The hardest case to reach from the ports is a hardware flag set that lands in the same cycle as a software write clearing it. The bench raises the timer pulse together with a write of zero. It also times an external edge so that the detection cycle coincides with a clearing write. The gating equations are swept over all 256 register values, each combined with several peripheral flag/enable patterns. The flags are loaded through software writes, so every gating term can be reached without waiting on the pins.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int REG_W    = 8;
  localparam int PORT_W   = 4;
  localparam int B_GLOBAL = 7;
  localparam int B_PERIPH = 6;
  localparam int B_TMR_EN = 5;
  localparam int B_EXT_EN = 4;
  localparam int B_PRT_EN = 3;
  localparam int B_TMR_F  = 2;
  localparam int B_EXT_F  = 1;
  localparam int B_PRT_F  = 0;
  localparam int NCORE    = 3;

  typedef struct packed {
    logic tmr;
    logic ext;
    logic prt;
  } core_evt_t;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int W = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/intc_detect.sv
module intc_detect
  import intc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_s,
  input  logic              edge_rise,
  input  logic [PORT_W-1:0] port_s,
  input  logic              tmr_ovf,
  output core_evt_t         evt
);
  logic              ext_prev;
  logic [PORT_W-1:0] port_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_prev  <= 1'b0;
      port_prev <= '0;
    end else begin
      ext_prev  <= ext_s;
      port_prev <= port_s;
    end
  end

  always_comb begin
    evt.tmr = tmr_ovf;
    evt.ext = edge_rise ? (ext_s & ~ext_prev) : (~ext_s & ext_prev);
    evt.prt = |(port_s ^ port_prev);
  end
endmodule

// File: rtl/intc_ctrl_reg.sv
module intc_ctrl_reg
  import intc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  core_evt_t        evt,
  output logic [REG_W-1:0] q
);
  logic [REG_W-1:0] hw_set;

  always_comb begin
    hw_set          = '0;
    hw_set[B_TMR_F] = evt.tmr;
    hw_set[B_EXT_F] = evt.ext;
    hw_set[B_PRT_F] = evt.prt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else if (wr) q <= wdata | hw_set;
    else         q <= q | hw_set;
  end
endmodule

// File: rtl/intc_gate.sv
module intc_gate
  import intc_pkg::*;
#(
  parameter int NPER = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_pin,
  input  logic              edge_rise,
  input  logic [PORT_W-1:0] port_hi,
  input  logic              tmr_ovf,
  input  logic [NPER-1:0]   per_flag,
  input  logic [NPER-1:0]   per_en,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              cpu_irq,
  output logic              wake
);
  localparam int SYNC_W = PORT_W + 1;

  logic [SYNC_W-1:0] raw_in, sync_out;
  core_evt_t         evt;
  logic [REG_W-1:0]  ctl;
  logic [NCORE-1:0]  core_hit;
  logic              per_hit;

  assign raw_in = {ext_pin, port_hi};

  intc_sync #(.W(SYNC_W), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_out)
  );

  intc_detect u_det (
    .clk(clk), .rst_n(rst_n),
    .ext_s(sync_out[SYNC_W-1]), .edge_rise(edge_rise),
    .port_s(sync_out[PORT_W-1:0]), .tmr_ovf(tmr_ovf), .evt(evt)
  );

  intc_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
    .evt(evt), .q(ctl)
  );

  assign core_hit[0] = ctl[B_PRT_F] & ctl[B_PRT_EN];
  assign core_hit[1] = ctl[B_EXT_F] & ctl[B_EXT_EN];
  assign core_hit[2] = ctl[B_TMR_F] & ctl[B_TMR_EN];
  assign per_hit     = ctl[B_PERIPH] & |(per_flag & per_en);

  assign reg_rdata = ctl;
  assign wake      = |core_hit | per_hit;
  assign cpu_irq   = wake & ctl[B_GLOBAL];
endmodule

// File: rtl/intc_gate_chk.sv
module intc_gate_chk #(
  parameter int NPER = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tmr_ovf,
  input logic            reg_wr,
  input logic [7:0]      reg_rdata,
  input logic            cpu_irq,
  input logic            wake
);
  // R9: a CPU request always implies wake
  p_irq_implies_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> wake);
  // R9: no request with the global enable clear
  p_no_irq_without_global_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[7] |-> !cpu_irq);
  // R4 and R7: a timer pulse sets its flag next cycle, even against a write
  p_tmr_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf |=> reg_rdata[2]);
  // R6: flags hold without a write
  p_sticky_tmr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[2] && !reg_wr) |=> reg_rdata[2]);
  p_sticky_ext_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[1] && !reg_wr) |=> reg_rdata[1]);
  p_sticky_prt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[0] && !reg_wr) |=> reg_rdata[0]);
  // R2: enable bits change only through a write
  p_enables_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(reg_rdata[7:3]));
endmodule

bind intc_gate intc_gate_chk #(.NPER(NPER)) u_chk (
  .clk(clk), .rst_n(rst_n), .tmr_ovf(tmr_ovf), .reg_wr(reg_wr),
  .reg_rdata(reg_rdata), .cpu_irq(cpu_irq), .wake(wake)
);

// File: tb/intc_gate_tb.sv
module intc_gate_tb;
  localparam int NPER = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            ext_pin = 1'b0;
  logic            edge_rise = 1'b1;
  logic [3:0]      port_hi = '0;
  logic            tmr_ovf = 1'b0;
  logic [NPER-1:0] per_flag = '0;
  logic [NPER-1:0] per_en = '0;
  logic            reg_wr = 1'b0;
  logic [7:0]      reg_wdata = '0;
  logic [7:0]      reg_rdata;
  logic            cpu_irq, wake;

  int errors = 0;
  int checks = 0;

  always #5ns clk = ~clk;

  intc_gate #(.NPER(NPER)) u_dut (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .edge_rise(edge_rise),
    .port_hi(port_hi), .tmr_ovf(tmr_ovf), .per_flag(per_flag), .per_en(per_en),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_irq(cpu_irq), .wake(wake)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic clocks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic model_wake(input logic [7:0] r, input logic [NPER-1:0] pf,
                                      input logic [NPER-1:0] pe);
    return (r[0] & r[3]) | (r[1] & r[4]) | (r[2] & r[5]) | (r[6] & |(pf & pe));
  endfunction

  initial begin
    #2ms;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [NPER-1:0] pfs [4];
    logic [NPER-1:0] pes [4];
    logic ew;
    pfs[0] = 8'h00; pes[0] = 8'h00;
    pfs[1] = 8'h10; pes[1] = 8'h10;
    pfs[2] = 8'h10; pes[2] = 8'h01;
    pfs[3] = 8'hFF; pes[3] = 8'h00;

    // R1 reset state
    clocks(3);
    chk("R1 rdata in reset", reg_rdata, 8'h00);
    chk("R1 wake in reset", wake, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rdata after release", reg_rdata, 8'h00);
    chk("R1 irq after release", cpu_irq, 0);

    // R2 R8 R9 sweep over all register values
    for (int r = 0; r < 256; r++) begin
      wr(r[7:0]);
      chk("R2 readback", reg_rdata, r);
      for (int p = 0; p < 4; p++) begin
        per_flag = pfs[p]; per_en = pes[p];
        #1;
        ew = model_wake(r[7:0], pfs[p], pes[p]);
        chk("R8 wake", wake, ew);
        chk("R9 cpu_irq", cpu_irq, ew & r[7]);
      end
    end
    per_flag = '0; per_en = '0;

    // R3 external rising edge, latency
    wr(8'h00);
    edge_rise = 1'b1;
    @(negedge clk); ext_pin = 1'b1;
    clocks(2);
    chk("R3 no flag before 3rd edge", reg_rdata[1], 0);
    clocks(1);
    chk("R3 rising edge sets flag", reg_rdata[1], 1);
    wr(8'h00);
    @(negedge clk); ext_pin = 1'b0;
    clocks(4);
    chk("R3 falling edge ignored in rising mode", reg_rdata[1], 0);
    edge_rise = 1'b0;
    clocks(2);
    chk("R3 polarity change alone no flag", reg_rdata[1], 0);
    @(negedge clk); ext_pin = 1'b1;
    clocks(4);
    chk("R3 rising ignored in falling mode", reg_rdata[1], 0);
    @(negedge clk); ext_pin = 1'b0;
    clocks(3);
    chk("R3 falling edge sets flag", reg_rdata[1], 1);
    wr(8'h10);
    chk("R6 write clears ext flag", reg_rdata[1], 0);

    // R4 timer pulse
    @(negedge clk); tmr_ovf = 1'b1;
    @(negedge clk); tmr_ovf = 1'b0;
    chk("R4 timer flag set", reg_rdata[2], 1);
    clocks(5);
    chk("R6 timer flag sticky", reg_rdata[2], 1);

    // R7 hw set vs write of zero
    wr(8'h00);
    @(negedge clk); tmr_ovf = 1'b1; reg_wr = 1'b1; reg_wdata = 8'h00;
    @(negedge clk); tmr_ovf = 1'b0; reg_wr = 1'b0;
    chk("R7 timer set beats write", reg_rdata[2], 1);
    // R7 external edge detect cycle coinciding with write
    wr(8'h00);
    edge_rise = 1'b1;
    @(negedge clk); ext_pin = 1'b1;
    clocks(2);
    reg_wr = 1'b1; reg_wdata = 8'h00;
    @(negedge clk); reg_wr = 1'b0;
    chk("R7 ext set beats write", reg_rdata[1], 1);
    wr(8'h00);

    // R5 port change for every value
    for (int v = 1; v < 16; v++) begin
      @(negedge clk); port_hi = v[3:0];
      clocks(2);
      chk("R5 no flag before 3rd edge", reg_rdata[0], 0);
      clocks(1);
      chk("R5 port change sets flag", reg_rdata[0], 1);
      clocks(2);
      wr(8'h00);
      chk("R6 port flag cleared by write", reg_rdata[0], 0);
    end
    clocks(4);
    chk("R5 stable port no flag", reg_rdata[0], 0);

    // R8 wake independent of global enable, R9 gated
    wr(8'h28); @(negedge clk); tmr_ovf = 1'b1; @(negedge clk); tmr_ovf = 1'b0;
    chk("R8 wake without global", wake, 1);
    chk("R9 no irq without global", cpu_irq, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule